// File: doc/BRIEF.md
# T1 Transmit Framing-Bit Inserter

This block sits in a T1 transmit path and receives the outgoing line bits as a serial stream, one bit per beat. A marker travels with the first bit of each 193-bit frame. That first bit is the framing bit, and the block replaces it with locally generated content. The rest of the frame is 24 channels of 8 bits, and those bits pass through unchanged. Two multiframe structures are supported: a 12-frame superframe and a 24-frame extended superframe. In the extended superframe, the framing position carries three things in fixed frames: an alignment pattern, a 6-bit CRC of the previous extended superframe, and data-link bits taken from an external arbiter.

Each source of framing content has its own bypass control, and a global disable leaves every framing bit as received. A diagnostic mimic mode copies the transmitted framing bit of a frame into the first bit of each channel of that frame. A superframe-start strobe and a frame-number bus are brought out so that a bench can line up positions against a model.

The stream interface uses valid/ready. The block holds no data of its own, so `in_ready` follows `out_ready` and `out_valid` follows `in_valid` in the same cycle. A beat moves only when valid and ready are both high. While a beat is stalled, the upstream side must hold the data, the marker and the side inputs (`x_bit`, `dl_bit`) stable. Position counters advance only on accepted beats.

Top module: `fbit_inserter`

## Requirements
- R1: A beat with `in_sof` high is a framing bit. `frame_num` counts frames 1 to 12 (superframe) or 1 to 24 (extended superframe) and moves to the next value on each framing beat. It wraps to 1 after the last frame of the selected format, and also wraps to 1 when the count already exceeds that format's length. `frame_num` reads 0 after reset until the first framing beat. `sf_start` is high on a valid framing beat of frame 1.
- R2: In the superframe format, frames 1 to 11 send the framing bits 1,0,0,0,1,1,0,1,1,1,0 in order. Frame 12 sends the value of `x_bit`.
- R3: In the extended superframe, frames 4, 8, 12, 16, 20 and 24 send 0,0,1,0,1,1 in that order.
- R4: In the extended superframe, frames 2, 6, 10, 14, 18 and 22 send the held CRC bits 5 down to 0, most significant bit first. When `crc_byp` is high, the received bit passes through instead.
- R5: The CRC uses generator x^6+x+1, starts from zero and shifts in output bits most significant first. It covers every output beat from one frame-1 framing beat up to, but not including, the next frame-1 framing beat. On that next beat the result is captured, and it is what the following extended superframe sends. When `crc_j1` is low, framing bits count as 1 in the calculation. When `crc_j1` is high, they count as transmitted. The held value is zero until the first capture.
- R6: In the extended superframe, odd frames send `dl_bit`. When `dl_byp` is high, the received bit passes through instead.
- R7: When `fdis` is high, every framing bit passes through unchanged. When `fas_byp` is high, the superframe pattern positions (all 12 frames) and the extended-superframe alignment positions pass the received bit.
- R8: When `mimic_en` is high, the output bit at frame positions 1, 9, 17, ..., 185 (the first bit of each channel, counting the framing bit as position 0) equals the framing bit sent in that frame.
- R9: Every other non-framing bit passes through unchanged.
- R10: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. Frame and bit positions advance only on accepted beats, so random stalls do not shift any framing position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_data | input | 1 | Input line bit |
| in_sof | input | 1 | Marks the framing-bit beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 1 | Output line bit |
| fmt_esf | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| crc_j1 | input | 1 | CRC variant: 1 includes framing bits as sent |
| fdis | input | 1 | Global framing-bit replacement disable |
| fas_byp | input | 1 | Alignment pattern bypass |
| crc_byp | input | 1 | CRC bit bypass |
| dl_byp | input | 1 | Data-link bit bypass |
| mimic_en | input | 1 | Copy framing bit into first bit of each channel |
| x_bit | input | 1 | Value for superframe frame 12 |
| dl_bit | input | 1 | Data-link bit from the arbiter |
| sf_start | output | 1 | Frame-1 framing beat strobe |
| frame_num | output | 5 | Current frame number |

## Verification
The bench builds the block with its default parameters: 193-bit frames of 24 eight-bit channels. The framing positions and multiframe lengths therefore match the line format exactly, and a full extended superframe is 4632 beats. At that size, several complete multiframes fit into one run. The CRC captured in one extended superframe can then be checked bit by bit in the next, under both variants. The run also covers the switch between formats, where a frame count of 12 carries on into 13 and a count of 24 wraps to 1.

// File: rtl/fbit_pkg.sv
package fbit_pkg;
  localparam int SF_LEN  = 12;
  localparam int ESF_LEN = 24;
  localparam int CRC_W   = ESF_LEN / 4;

  // superframe pattern, frame 1 in the MSB; the LSB slot is replaced by x_bit
  localparam logic [SF_LEN-1:0] SF_ALIGN  = 12'b1000_1101_1100;
  // extended superframe alignment, frame 4 in the MSB
  localparam logic [CRC_W-1:0]  ESF_ALIGN = 6'b001011;
  // x^6 + x + 1, low terms only
  localparam logic [CRC_W-1:0]  CRC_POLY  = 6'b000011;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = d ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/fbit_position.sv
module fbit_position
  import fbit_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int CH_BITS    = 8,
  parameter int FW         = 5,
  parameter int BW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          valid,
  input  logic          sof,
  input  logic          esf,
  output logic [FW-1:0] frame_cur,
  output logic          chan_first
);
  logic [FW-1:0] frame_q, frame_next, last;
  logic [BW-1:0] bit_q;

  always_comb begin
    last = esf ? FW'(ESF_LEN) : FW'(SF_LEN);
    if (frame_q == '0 || frame_q >= last) frame_next = FW'(1);
    else                                  frame_next = frame_q + FW'(1);
    frame_cur = (valid && sof) ? frame_next : frame_q;
  end

  always_comb begin
    int rel;
    rel = int'(bit_q) - 1;
    chan_first = !sof && (bit_q != '0) && (int'(bit_q) < FRAME_BITS) && ((rel % CH_BITS) == 0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      bit_q   <= '0;
    end else if (adv) begin
      if (sof) begin
        frame_q <= frame_next;
        bit_q   <= BW'(1);
      end else if (bit_q != '0 && int'(bit_q) < FRAME_BITS) begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end
endmodule

// File: rtl/fbit_crc6.sv
module fbit_crc6
  import fbit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             boundary,
  input  logic             is_fbit,
  input  logic             j1_mode,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_hold
);
  logic [CRC_W-1:0] acc_q, base;
  logic             din;

  always_comb begin
    din  = (is_fbit && !j1_mode) ? 1'b1 : bit_in;
    base = boundary ? '0 : acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      crc_hold <= '0;
    end else if (adv) begin
      if (boundary) crc_hold <= acc_q;
      acc_q <= crc_step(base, din);
    end
  end
endmodule

// File: rtl/fbit_select.sv
module fbit_select
  import fbit_pkg::*;
#(
  parameter int FW = 5
) (
  input  logic             esf,
  input  logic [FW-1:0]    frame,
  input  logic             fdis,
  input  logic             fas_byp,
  input  logic             crc_byp,
  input  logic             dl_byp,
  input  logic             x_bit,
  input  logic             dl_bit,
  input  logic [CRC_W-1:0] crc_hold,
  input  logic             f_in,
  output logic             f_out
);
  always_comb begin
    int k;
    k     = int'(frame) / 4;
    f_out = f_in;
    if (!fdis) begin
      if (!esf) begin
        if (!fas_byp) begin
          if (int'(frame) == SF_LEN)                      f_out = x_bit;
          else if (frame != '0 && int'(frame) < SF_LEN)   f_out = SF_ALIGN[SF_LEN - int'(frame)];
        end
      end else begin
        case (frame[1:0])
          2'd0: if (!fas_byp && k >= 1 && k <= CRC_W) f_out = ESF_ALIGN[CRC_W - k];
          2'd2: if (!crc_byp && k < CRC_W)             f_out = crc_hold[CRC_W - 1 - k];
          default: if (!dl_byp)                        f_out = dl_bit;
        endcase
      end
    end
  end
endmodule

// File: rtl/fbit_inserter.sv
module fbit_inserter
  import fbit_pkg::*;
#(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8,
  localparam int FRAME_BITS = 1 + CHANNELS * CH_BITS,
  localparam int FW = $clog2(ESF_LEN + 1),
  localparam int BW = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_data,
  input  logic          in_sof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_data,
  input  logic          fmt_esf,
  input  logic          crc_j1,
  input  logic          fdis,
  input  logic          fas_byp,
  input  logic          crc_byp,
  input  logic          dl_byp,
  input  logic          mimic_en,
  input  logic          x_bit,
  input  logic          dl_bit,
  output logic          sf_start,
  output logic [FW-1:0] frame_num
);
  logic             adv, chan_first, f_out, f_val_q;
  logic [FW-1:0]    frame_cur;
  logic [CRC_W-1:0] crc_hold;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign adv       = in_valid && out_ready;

  fbit_position #(.FRAME_BITS(FRAME_BITS), .CH_BITS(CH_BITS), .FW(FW), .BW(BW)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(adv), .valid(in_valid), .sof(in_sof), .esf(fmt_esf),
    .frame_cur(frame_cur), .chan_first(chan_first)
  );

  fbit_select #(.FW(FW)) u_sel (
    .esf(fmt_esf), .frame(frame_cur), .fdis(fdis), .fas_byp(fas_byp), .crc_byp(crc_byp),
    .dl_byp(dl_byp), .x_bit(x_bit), .dl_bit(dl_bit), .crc_hold(crc_hold), .f_in(in_data),
    .f_out(f_out)
  );

  always_comb begin
    if (in_sof)                     out_data = f_out;
    else if (mimic_en && chan_first) out_data = f_val_q;
    else                            out_data = in_data;
  end

  assign sf_start  = in_valid && in_sof && (frame_cur == FW'(1));
  assign frame_num = frame_cur;

  fbit_crc6 u_crc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .boundary(sf_start), .is_fbit(in_sof),
    .j1_mode(crc_j1), .bit_in(out_data), .crc_hold(crc_hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             f_val_q <= 1'b0;
    else if (adv && in_sof) f_val_q <= f_out;
  end
endmodule

// File: rtl/fbit_checker.sv
module fbit_checker #(
  parameter int FW = 5,
  parameter int LAST_FRAME = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_data,
  input logic          in_sof,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_data,
  input logic          fmt_esf,
  input logic          fdis,
  input logic          fas_byp,
  input logic          mimic_en,
  input logic          sf_start,
  input logic [FW-1:0] frame_num
);
  assert_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == out_ready) && (out_valid == in_valid));

  assert_frame_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_num) <= LAST_FRAME);

  assert_sf_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |-> (in_valid && in_sof && frame_num == FW'(1)));

  assert_frame_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sof) |=> (in_sof || frame_num == $past(frame_num)));

  assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !mimic_en) |-> (out_data == in_data));

  assert_fdis_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && fdis) |-> (out_data == in_data));

  assert_esf_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && fmt_esf && !fdis && !fas_byp && frame_num == FW'(4)) |-> (out_data == 1'b0));
endmodule

bind fbit_inserter fbit_checker #(.FW(FW), .LAST_FRAME(fbit_pkg::ESF_LEN)) u_fbit_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .fmt_esf(fmt_esf), .fdis(fdis), .fas_byp(fas_byp), .mimic_en(mimic_en),
  .sf_start(sf_start), .frame_num(frame_num)
);

// File: tb/fbit_inserter_bench.sv
module fbit_inserter_bench;
  localparam int FB = 193;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_data = 0, in_sof = 0, out_ready = 0;
  logic fmt_esf = 1, crc_j1 = 0, fdis = 0, fas_byp = 0, crc_byp = 0, dl_byp = 0, mimic_en = 0;
  logic x_bit = 0, dl_bit = 0;
  logic in_ready, out_valid, out_data, sf_start;
  logic [4:0] frame_num;

  int tests = 0, fails = 0;
  bit done = 0;

  fbit_inserter u_fbit_inserter (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] m_step(input logic [5:0] c, input logic d);
    logic fb;
    fb = d ^ c[5];
    return {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b0);
  endfunction

  function automatic logic sf_pat(input int f, input logic x);
    logic p[12] = '{1, 0, 0, 0, 1, 1, 0, 1, 1, 1, 0, 0};
    return (f == 12) ? x : p[f-1];
  endfunction

  function automatic logic fas_pat(input int k);
    logic p[6] = '{0, 0, 1, 0, 1, 1};
    return p[k];
  endfunction

  int ph_frames[7] = '{48, 48, 24, 24, 12, 24, 24};

  task automatic set_phase(input int p);
    {fdis, fas_byp, crc_byp, dl_byp, mimic_en} = '0;
    fmt_esf = 1; crc_j1 = 0;
    case (p)
      1: crc_j1 = 1;
      2: begin crc_byp = 1; dl_byp = 1; end
      3: fmt_esf = 0;
      4: begin fmt_esf = 0; fas_byp = 1; end
      5: begin fdis = 1; mimic_en = 1; end
      6: begin mimic_en = 1; crc_j1 = 1; end
      default: ;
    endcase
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int bc = 0, mf = 0, phase = 0, frames_in_phase = 0;
    logic [5:0] acc = 0, hold = 0;
    logic fval = 0, exp_o;
    bit have = 0;
    void'($urandom(32'h5eed_1234));
    set_phase(0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check(out_valid == 0 && in_ready == 0, "R10 reset idle", out_valid, 0);
    check(frame_num == 0, "R1 reset frame_num", frame_num, 0);
    check(sf_start == 0, "R1 reset sf_start", sf_start, 0);
    while (phase < 7) begin
      @(negedge clk);
      if (!have) begin
        if (bc == 0) begin
          if (frames_in_phase == ph_frames[phase]) begin
            phase++; frames_in_phase = 0;
          end
          if (phase >= 7) break;
          set_phase(phase);
          frames_in_phase++;
        end
        in_data = 1'($urandom); in_sof = (bc == 0);
        x_bit = 1'($urandom); dl_bit = 1'($urandom);
        have = 1;
      end
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 4) != 0;
      #1;
      check(out_valid == in_valid && in_ready == out_ready, "R10 handshake", out_valid, in_valid);
      if (in_valid && out_ready) begin
        string tag;
        if (in_sof) begin
          int n, k;
          n  = fmt_esf ? 24 : 12;
          mf = (mf == 0 || mf >= n) ? 1 : mf + 1;
          k  = mf / 4;
          check(frame_num == 5'(mf), "R1 frame_num", frame_num, mf);
          check(sf_start == (mf == 1), "R1 sf_start", sf_start, mf == 1);
          exp_o = in_data; tag = "R7 fdis";
          if (!fdis) begin
            if (!fmt_esf) begin
              tag = "R2 superframe";
              if (!fas_byp) exp_o = sf_pat(mf, x_bit); else tag = "R7 bypass";
            end else if (mf % 4 == 0) begin
              tag = "R3 esf align";
              if (!fas_byp) exp_o = fas_pat(k - 1);
            end else if (mf % 4 == 2) begin
              tag = "R4 R5 crc";
              if (!crc_byp) exp_o = hold[5-k];
            end else begin
              tag = "R6 data link";
              if (!dl_byp) exp_o = dl_bit;
            end
          end
          fval = exp_o;
        end else if (mimic_en && bc >= 1 && ((bc - 1) % 8) == 0) begin
          exp_o = fval; tag = "R8 mimic";
        end else begin
          exp_o = in_data; tag = "R9 passthrough";
        end
        check(out_data == exp_o, tag, out_data, exp_o);
        if (in_sof && mf == 1) begin
          hold = acc;
          acc  = m_step(6'd0, (in_sof && !crc_j1) ? 1'b1 : exp_o);
        end else begin
          acc  = m_step(acc, (in_sof && !crc_j1) ? 1'b1 : exp_o);
        end
        bc = (bc + 1) % FB;
        have = 0;
      end
    end
    @(negedge clk); in_valid = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule